// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, through a pair of storage registers, one per direction. On each side the block either forwards the live word from the opposite bus or replays a word it captured earlier. Each direction has its own capture strobe, its own live-or-stored select and its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. A build-time parameter selects an inverting variant, in which every driven word is the complement of the selected source.

The shared bus wires are modelled as separate input, output and output-enable vectors, so the block stays synthesizable. The surrounding logic resolves each bus from the block's output-enable, its output and any external driver, then feeds the resolved value back into the input vector. Capture always takes that resolved value, so a word the block drives onto one bus can be stored in that bus's register as well. This loop-back path is how one word gets copied into both registers.

One usage rule applies. When both sides drive and both select live data, the two paths form a combinational loop. Surrounding logic must not request that combination.

Top module: `dual_reg_xcvr`

## Requirements
- R1: The word width is the parameter DATA_W (default 8). Every bit lane behaves identically and is steered by the same control inputs.
- R2: On a rising `clk` edge with `captureA` high, the A register loads `aIn`. With `captureA` low it keeps its value.
- R3: On a rising `clk` edge with `captureB` high, the B register loads `bIn`. With `captureB` low it keeps its value.
- R4: `bOut` carries live `aIn` when `selAtoB` is 0 and the stored A register when `selAtoB` is 1.
- R5: `aOut` carries live `bIn` when `selBtoA` is 0 and the stored B register when `selBtoA` is 1.
- R6: `bOe` is all ones when `enAtoB` is 1 and all zeros otherwise. `aOe` is all ones when `enBtoAN` is 0 and all zeros otherwise.
- R7: With `enAtoB` = 0 and `enBtoAN` = 1, neither side drives, and each register still captures or holds its own bus independently.
- R8: Capture is never gated by the enables. A register clocked while the block drives its bus stores the driven word, so a single capture edge can put the same word into both registers.
- R9: With INVERT = 1, `aOut` and `bOut` are the bitwise complement of the selected live or stored word. The registers store the resolved bus value as seen.
- R10: With `rst` high at a rising `clk` edge, both registers become zero. Reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; capture happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset of both registers |
| captureA | input | 1 | Load the A register from the resolved A bus |
| captureB | input | 1 | Load the B register from the resolved B bus |
| selAtoB | input | 1 | 0: live A word to B side, 1: stored A word |
| selBtoA | input | 1 | 0: live B word to A side, 1: stored B word |
| enAtoB | input | 1 | Active-high enable of the B-side drivers |
| enBtoAN | input | 1 | Active-low enable of the A-side drivers |
| aIn | input | DATA_W | Resolved value on the A bus |
| aOut | output | DATA_W | Word offered to the A bus |
| aOe | output | DATA_W | Per-lane drive enable for the A bus |
| bIn | input | DATA_W | Resolved value on the B bus |
| bOut | output | DATA_W | Word offered to the B bus |
| bOe | output | DATA_W | Per-lane drive enable for the B bus |

## Verification
The bench targets the loop-back capture, where the block drives live A data onto B while both registers are clocked. A design that captured from its internal mux output, or that gated capture with the enables, would leave the B register stale or hold the wrong polarity in the inverting variant. The bench also exercises the opposite polarities of the two enables: a design that swapped one polarity would drive a bus while the buses are isolated. Stored-versus-live selection is checked directly after capture and across hold cycles, which catches a register that loads when it should hold. Both sides also drive at once with one side replaying stored data, which catches a mux tied to the wrong register.

// File: rtl/dual_xcvr_pkg.sv
package dual_xcvr_pkg;

  // Strobes decoded by the control unit and consumed by the datapath
  typedef struct packed {
    logic loadA;      // capture resolved A bus into the A register
    logic loadB;      // capture resolved B bus into the B register
    logic storedToB;  // B side replays the A register instead of live A
    logic storedToA;  // A side replays the B register instead of live B
    logic driveB;     // B-side drivers on
    logic driveA;     // A-side drivers on
  } xcvrStrobes_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import dual_xcvr_pkg::*;
(
  input  logic         captureA,
  input  logic         captureB,
  input  logic         selAtoB,
  input  logic         selBtoA,
  input  logic         enAtoB,
  input  logic         enBtoAN,
  output xcvrStrobes_t strobes
);

  always_comb begin
    strobes           = '0;
    // capture is independent of the enables (R8)
    strobes.loadA     = captureA;
    strobes.loadB     = captureB;
    strobes.storedToB = selAtoB;
    strobes.storedToA = selBtoA;
    // opposite polarities of the two enables (R6)
    strobes.driveB    = enAtoB;
    strobes.driveA    = ~enBtoAN;
  end

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import dual_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  xcvrStrobes_t      strobes,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] aOe,
  output logic [DATA_W-1:0] bOut,
  output logic [DATA_W-1:0] bOe
);

  localparam int LANES = DATA_W;

  logic [DATA_W-1:0] regA;
  logic [DATA_W-1:0] regB;
  logic [DATA_W-1:0] toBWord;
  logic [DATA_W-1:0] toAWord;

  // A-side register, captures the resolved A bus (R2, R10)
  always_ff @(posedge clk) begin
    if (rst)                regA <= '0;
    else if (strobes.loadA) regA <= aIn;
  end

  // B-side register, captures the resolved B bus (R3, R10)
  always_ff @(posedge clk) begin
    if (rst)                regB <= '0;
    else if (strobes.loadB) regB <= bIn;
  end

  // live-or-stored selection per direction (R4, R5)
  always_comb begin
    toBWord = strobes.storedToB ? regA : aIn;
    toAWord = strobes.storedToA ? regB : bIn;
  end

  // identical lanes; the parameter picks the polarity of the driven word (R1, R9)
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    if (INVERT) begin : g_inv
      assign bOut[lane] = ~toBWord[lane];
      assign aOut[lane] = ~toAWord[lane];
    end else begin : g_true
      assign bOut[lane] = toBWord[lane];
      assign aOut[lane] = toAWord[lane];
    end
    assign bOe[lane] = strobes.driveB;
    assign aOe[lane] = strobes.driveA;
  end

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import dual_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              captureA,
  input  logic              captureB,
  input  logic              selAtoB,
  input  logic              selBtoA,
  input  logic              enAtoB,
  input  logic              enBtoAN,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] aOe,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] bOut,
  output logic [DATA_W-1:0] bOe
);

  xcvrStrobes_t strobes;

  xcvr_ctrl u_ctrl (
    .captureA (captureA),
    .captureB (captureB),
    .selAtoB  (selAtoB),
    .selBtoA  (selBtoA),
    .enAtoB   (enAtoB),
    .enBtoAN  (enBtoAN),
    .strobes  (strobes)
  );

  xcvr_datapath #(
    .DATA_W (DATA_W),
    .INVERT (INVERT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .aIn     (aIn),
    .bIn     (bIn),
    .aOut    (aOut),
    .aOe     (aOe),
    .bOut    (bOut),
    .bOe     (bOe)
  );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int DATA_W = 8,
  parameter bit INVERT = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              captureA,
  input logic              captureB,
  input logic              selAtoB,
  input logic              selBtoA,
  input logic              enAtoB,
  input logic              enBtoAN,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] aOut,
  input logic [DATA_W-1:0] aOe,
  input logic [DATA_W-1:0] bIn,
  input logic [DATA_W-1:0] bOut,
  input logic [DATA_W-1:0] bOe
);

  function automatic logic [DATA_W-1:0] xf(input logic [DATA_W-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  // R2: a captured A word is replayed on B in the next cycle
  p_capture_a_r2: assert property (@(posedge clk) disable iff (rst)
    captureA ##1 selAtoB |-> bOut == xf($past(aIn)));

  // R2: without capture the replayed A word does not move
  p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
    (selAtoB && !captureA) ##1 selAtoB |-> $stable(bOut));

  // R3: a captured B word is replayed on A in the next cycle
  p_capture_b_r3: assert property (@(posedge clk) disable iff (rst)
    captureB ##1 selBtoA |-> aOut == xf($past(bIn)));

  // R4, R9: live path towards B
  p_live_to_b_r4: assert property (@(posedge clk) disable iff (rst)
    !selAtoB |-> bOut == xf(aIn));

  // R5, R9: live path towards A
  p_live_to_a_r5: assert property (@(posedge clk) disable iff (rst)
    !selBtoA |-> aOut == xf(bIn));

  // R6: enable polarities
  p_b_enable_r6: assert property (@(posedge clk) disable iff (rst)
    enAtoB |-> bOe == {DATA_W{1'b1}});
  p_a_enable_r6: assert property (@(posedge clk) disable iff (rst)
    !enBtoAN |-> aOe == {DATA_W{1'b1}});

  // R7: isolation drives neither bus
  p_isolated_r7: assert property (@(posedge clk) disable iff (rst)
    (!enAtoB && enBtoAN) |-> (aOe == '0 && bOe == '0));

  // R10: reset clears the A register, visible through the stored path
  p_reset_r10: assert property (@(posedge clk)
    rst ##1 selAtoB |-> bOut == xf('0));

endmodule

bind dual_reg_xcvr xcvr_checker #(
  .DATA_W (DATA_W),
  .INVERT (INVERT)
) chk (
  .clk      (clk),
  .rst      (rst),
  .captureA (captureA),
  .captureB (captureB),
  .selAtoB  (selAtoB),
  .selBtoA  (selBtoA),
  .enAtoB   (enAtoB),
  .enBtoAN  (enBtoAN),
  .aIn      (aIn),
  .aOut     (aOut),
  .aOe      (aOe),
  .bIn      (bIn),
  .bOut     (bOut),
  .bOe      (bOe)
);

// File: tb/tb_dual_reg_xcvr.sv
`timescale 1ns/1ps
module tb_dual_reg_xcvr;

  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic captureA = 0, captureB = 0, selAtoB = 0, selBtoA = 0;
  logic enAtoB = 0, enBtoAN = 1;
  logic [W-1:0] aExt = '0, bExt = '0;

  // true-polarity instance and its bus resolver
  logic [W-1:0] aOut0, aOe0, bOut0, bOe0, aBus0, bBus0;
  assign aBus0 = (aOe0 & aOut0) | (~aOe0 & aExt);
  assign bBus0 = (bOe0 & bOut0) | (~bOe0 & bExt);

  // inverting instance and its bus resolver
  logic [W-1:0] aOut1, aOe1, bOut1, bOe1, aBus1, bBus1;
  assign aBus1 = (aOe1 & aOut1) | (~aOe1 & aExt);
  assign bBus1 = (bOe1 & bOut1) | (~bOe1 & bExt);

  dual_reg_xcvr #(.DATA_W(W), .INVERT(1'b0)) dut (
    .clk(clk), .rst(rst), .captureA(captureA), .captureB(captureB),
    .selAtoB(selAtoB), .selBtoA(selBtoA), .enAtoB(enAtoB), .enBtoAN(enBtoAN),
    .aIn(aBus0), .aOut(aOut0), .aOe(aOe0),
    .bIn(bBus0), .bOut(bOut0), .bOe(bOe0));

  dual_reg_xcvr #(.DATA_W(W), .INVERT(1'b1)) dutInv (
    .clk(clk), .rst(rst), .captureA(captureA), .captureB(captureB),
    .selAtoB(selAtoB), .selBtoA(selBtoA), .enAtoB(enAtoB), .enBtoAN(enBtoAN),
    .aIn(aBus1), .aOut(aOut1), .aOe(aOe1),
    .bIn(bBus1), .bOut(bOut1), .bOe(bOe1));

  int checkCount = 0;
  int failCount = 0;
  logic [W-1:0] modelA [2];
  logic [W-1:0] modelB [2];

  function automatic logic [W-1:0] xf(input bit inv, input logic [W-1:0] v);
    return inv ? ~v : v;
  endfunction

  // reference resolution of both buses; both-live-both-driving is never requested
  function automatic void resolve(input bit inv, input logic [W-1:0] rA, input logic [W-1:0] rB,
                                  output logic [W-1:0] aB, output logic [W-1:0] bB,
                                  output logic [W-1:0] aO, output logic [W-1:0] bO);
    bit drvA = !enBtoAN;
    bit drvB = enAtoB;
    aB = aExt;
    bB = bExt;
    if (drvB && selAtoB) bB = xf(inv, rA);
    if (drvA && selBtoA) aB = xf(inv, rB);
    if (drvB && !selAtoB) bB = xf(inv, aB);
    if (drvA && !selBtoA) aB = xf(inv, bB);
    aO = xf(inv, selBtoA ? rB : bB);
    bO = xf(inv, selAtoB ? rA : aB);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit r, input bit cA, input bit cB,
                      input bit sAB, input bit sBA, input bit eAB, input bit eBAN,
                      input logic [W-1:0] aE, input logic [W-1:0] bE);
    @(negedge clk);
    rst = r; captureA = cA; captureB = cB; selAtoB = sAB; selBtoA = sBA;
    enAtoB = eAB; enBtoAN = eBAN; aExt = aE; bExt = bE;
    #1;
    for (int inst = 0; inst < 2; inst++) begin
      logic [W-1:0] aB, bB, aO, bO;
      resolve(inst == 1, modelA[inst], modelB[inst], aB, bB, aO, bO);
      if (inst == 0) begin
        check(tag, "bOut", bOut0, bO);
        check(tag, "aOut", aOut0, aO);
        check({tag, " R6"}, "bOe", bOe0, {W{eAB}});
        check({tag, " R6"}, "aOe", aOe0, {W{!eBAN}});
      end else begin
        check({tag, " R9"}, "inv bOut", bOut1, bO);
        check({tag, " R9"}, "inv aOut", aOut1, aO);
        check({tag, " R6"}, "inv bOe", bOe1, {W{eAB}});
        check({tag, " R6"}, "inv aOe", aOe1, {W{!eBAN}});
      end
      // register update at the coming rising edge
      if (r) begin
        modelA[inst] = '0;
        modelB[inst] = '0;
      end else begin
        if (cA) modelA[inst] = aB;
        if (cB) modelB[inst] = bB;
      end
    end
  endtask

  initial begin
    #1_000_000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0651);
    modelA[0] = '0; modelA[1] = '0; modelB[0] = '0; modelB[1] = '0;

    // R10: reset clears both registers, seen through the stored paths
    step("R10 reset", 1, 0, 0, 1, 1, 0, 1, 8'h11, 8'h22);
    step("R10 reset", 1, 1, 1, 1, 1, 0, 1, 8'h33, 8'h44);
    step("R10 cleared", 0, 0, 0, 1, 1, 0, 1, 8'hA5, 8'h5A);

    // R7, R2, R3: isolated, each side stores its own bus
    step("R7 isolated capture", 0, 1, 1, 1, 1, 0, 1, 8'h5A, 8'hC3);
    step("R7 R2 R3 stored view", 0, 0, 0, 1, 1, 0, 1, 8'h00, 8'hFF);
    // R2, R3: hold with strobes low while the buses change
    step("R2 R3 hold", 0, 0, 0, 1, 1, 0, 1, 8'h81, 8'h7E);

    // R4: live A to B, then stored A to B
    step("R4 live", 0, 0, 0, 0, 1, 1, 1, 8'h96, 8'h00);
    step("R4 stored", 0, 0, 0, 1, 1, 1, 1, 8'h96, 8'h00);
    // R5: live B to A, then stored B to A
    step("R5 live", 0, 0, 0, 1, 0, 0, 0, 8'h00, 8'h69);
    step("R5 stored", 0, 0, 0, 1, 1, 0, 0, 8'h00, 8'h69);

    // R8: drive live A onto B and clock both registers
    step("R8 loop-back A", 0, 1, 1, 0, 1, 1, 1, 8'h3C, 8'h00);
    step("R8 both hold A", 0, 0, 0, 1, 1, 1, 0, 8'hEE, 8'hDD);
    // R8: drive live B onto A and clock both registers
    step("R8 loop-back B", 0, 1, 1, 1, 0, 0, 0, 8'h00, 8'hB2);
    step("R8 both hold B", 0, 0, 0, 1, 1, 1, 0, 8'h12, 8'h34);

    // R6: both sides drive, one live and one stored
    step("R6 dual drive", 0, 1, 0, 0, 1, 1, 0, 8'h00, 8'h00);
    step("R6 dual drive", 0, 0, 1, 1, 0, 1, 0, 8'h00, 8'h00);
    step("R1 all ones", 0, 1, 1, 1, 1, 0, 1, 8'hFF, 8'hFF);
    step("R1 all ones view", 0, 0, 0, 1, 1, 1, 0, 8'h00, 8'h00);

    // R1: random control and data mixes
    for (int n = 0; n < 3000; n++) begin
      bit r, cA, cB, sAB, sBA, eAB, eBAN;
      r = ($urandom % 64) == 0;
      cA = $urandom; cB = $urandom; sAB = $urandom; sBA = $urandom;
      eAB = $urandom; eBAN = $urandom;
      if (eAB && !eBAN && !sAB && !sBA) sBA = 1'b1;
      step("R1 random", r, cA, cB, sAB, sBA, eAB, eBAN, W'($urandom), W'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule